// File: doc/BRIEF.md
# I2C Multi-Slot Address Matcher

This block watches the address phase of an I2C transfer and decides whether the local node is being addressed. It receives whole bytes from a separate bit shifter, as a byte value with a one-cycle valid strobe. It also receives a one-cycle START pulse, three programmable slot addresses and two mode bits. It reports a decision flag, a match flag, the index of the matching slot, a general-call flag and the transfer direction. Shifting bits and driving ACK are handled elsewhere.

Each slot register is 10 bits wide. In 7-bit mode, the first byte after START carries the address in bits [7:1] and the direction in bit [0]. Address bits [7:1] are compared with bits [9:3] of every slot. In 10-bit mode, the first byte must carry the prefix 11110 in bits [7:3], followed by two high address bits in [2:1] and the direction in [0]. The second byte is compared with the low eight bits of each slot. Setting the free-data bit disables address recognition, so that every transfer is accepted without an address byte.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While rst_ni is low, or in the cycle after any cycle with enable_i low, all five outputs are 0. Bytes that arrive before the first START after reset or enable are ignored.
- R2: A START seen while enabled clears all outputs in the next cycle. A byte strobe in the same cycle as START is discarded.
- R3: In 7-bit mode, one cycle after the first byte strobe, done_o=1, rw_o=byte[0] (1 = read), and match_o=1 exactly when byte[7:1] equals bits [9:3] of some slot. Slot bits [2:0] have no effect.
- R4: With addressing enabled and in either width mode, a first byte of 0x00 gives done_o=1, match_o=1, gcall_o=1, match_idx_o=0 and rw_o=0 one cycle later.
- R5: In 10-bit mode, a first byte with [7:3]=11110 leaves done_o at 0 and the block waits for a second byte. One cycle after the second strobe, done_o=1 and rw_o is bit [0] of the first byte. match_o=1 only for a slot whose bits [9:8] equal first-byte bits [2:1] and whose bits [7:0] equal the second byte.
- R6: When several slots match, match_idx_o reports the lowest index. match_idx_o is 0 when there is no match.
- R7: With free_data_i=1, one cycle after START the outputs are done_o=1, match_o=1, gcall_o=0, match_idx_o=0 and rw_o=0. Later bytes have no effect.
- R8: Once done_o=1, further byte strobes leave all outputs unchanged until the next START or disable.
- R9: A first byte with no match, or a 10-bit first byte without the prefix that is not 0x00, gives done_o=1, match_o=0, gcall_o=0 and match_idx_o=0 one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low clears all state |
| start_i | input | 1 | One-cycle pulse marking a START condition |
| byte_valid_i | input | 1 | One-cycle strobe for byte_i |
| byte_i | input | 8 | Received byte |
| free_data_i | input | 1 | 1: accept every transfer without addressing |
| ten_bit_i | input | 1 | 1: 10-bit compare, 0: 7-bit compare |
| slot_addr_i | input | NUM_SLOTS*10 | Slot addresses, slot k in bits [10k+9:10k] |
| done_o | output | 1 | Address decision available |
| match_o | output | 1 | Node addressed |
| match_idx_o | output | IDX_W | Index of the lowest matching slot |
| gcall_o | output | 1 | General call received |
| rw_o | output | 1 | Direction bit, 1 = read |

## Verification
The two events that can fall in the same cycle are a START pulse and a byte strobe. The bench provokes this right after a completed match by raising both together, with a byte that would match. It then checks three things in turn. First, the outputs are cleared in the next cycle. Second, done_o is still 0 in the cycle after that, which shows the coincident byte was dropped. Third, a later strobe of the same byte produces the match. A second pairing, disable together with START, is checked by pulsing START while enable_i is low and confirming that the following byte produces no decision.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned A7_W   = 7;
  localparam int unsigned HI_W   = 2;
  localparam int unsigned LO_W   = 8;
  localparam logic [4:0]  TEN_PREFIX = 5'b11110;
  localparam logic [7:0]  GCALL_BYTE = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } am_state_e;
endpackage

// File: rtl/i2c_am_slot_cmp.sv
module i2c_am_slot_cmp
  import i2c_am_pkg::*;
(
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [7:0]        byte_i,
  output logic              hit7_o,
  output logic              hi10_o,
  output logic              lo10_o
);
  // 7-bit: upper seven slot bits against byte[7:1]
  assign hit7_o = (byte_i[7:1] == slot_addr_i[ADDR_W-1 -: A7_W]);
  // 10-bit: high pair against byte[2:1], low byte against whole second byte
  assign hi10_o = (byte_i[2:1] == slot_addr_i[ADDR_W-1 -: HI_W]);
  assign lo10_o = (byte_i == slot_addr_i[LO_W-1:0]);
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = N'(1) << i;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic                          start_i,
  input  logic                          byte_valid_i,
  input  logic [7:0]                    byte_i,
  input  logic                          free_data_i,
  input  logic                          ten_bit_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   slot_addr_i,
  output logic                          done_o,
  output logic                          match_o,
  output logic [IDX_W-1:0]              match_idx_o,
  output logic                          gcall_o,
  output logic                          rw_o
);
  am_state_e state_q, state_d;
  logic [NUM_SLOTS-1:0] hi_mask_q, hi_mask_d;
  logic done_q, done_d, match_q, match_d, gcall_q, gcall_d, rw_q, rw_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic [NUM_SLOTS-1:0] hit7, hi10, lo10, req;
  logic [NUM_SLOTS-1:0] grant;
  logic                 req_any;
  logic [IDX_W-1:0]     req_idx;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    i2c_am_slot_cmp u_cmp (
      .slot_addr_i (slot_addr_i[g*ADDR_W +: ADDR_W]),
      .byte_i      (byte_i),
      .hit7_o      (hit7[g]),
      .hi10_o      (hi10[g]),
      .lo10_o      (lo10[g])
    );
  end

  // one encoder shared by both compare phases
  assign req = (state_q == ST_SECOND) ? (hi_mask_q & lo10) : hit7;

  i2c_am_prio #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_prio (
    .req_i   (req),
    .any_o   (req_any),
    .grant_o (grant),
    .idx_o   (req_idx)
  );

  always_comb begin
    state_d   = state_q;
    hi_mask_d = hi_mask_q;
    done_d    = done_q;
    match_d   = match_q;
    gcall_d   = gcall_q;
    rw_d      = rw_q;
    idx_d     = idx_q;
    if (!enable_i) begin
      state_d = ST_IDLE; hi_mask_d = '0;
      done_d = 1'b0; match_d = 1'b0; gcall_d = 1'b0; rw_d = 1'b0; idx_d = '0;
    end else if (start_i) begin
      // START wins over a coincident strobe
      hi_mask_d = '0;
      gcall_d = 1'b0; rw_d = 1'b0; idx_d = '0;
      if (free_data_i) begin
        state_d = ST_DONE; done_d = 1'b1; match_d = 1'b1;
      end else begin
        state_d = ST_FIRST; done_d = 1'b0; match_d = 1'b0;
      end
    end else if (byte_valid_i) begin
      unique case (state_q)
        ST_FIRST: begin
          if (byte_i == GCALL_BYTE) begin
            state_d = ST_DONE; done_d = 1'b1; match_d = 1'b1;
            gcall_d = 1'b1; rw_d = 1'b0; idx_d = '0;
          end else if (!ten_bit_i) begin
            state_d = ST_DONE; done_d = 1'b1; match_d = req_any;
            idx_d = req_idx; rw_d = byte_i[0];
          end else if (byte_i[7:3] == TEN_PREFIX) begin
            state_d = ST_SECOND; hi_mask_d = hi10; rw_d = byte_i[0];
          end else begin
            state_d = ST_DONE; done_d = 1'b1; match_d = 1'b0;
            idx_d = '0; rw_d = byte_i[0];
          end
        end
        ST_SECOND: begin
          state_d = ST_DONE; done_d = 1'b1; match_d = req_any; idx_d = req_idx;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hi_mask_q <= '0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      gcall_q   <= 1'b0;
      rw_q      <= 1'b0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_d;
      hi_mask_q <= hi_mask_d;
      done_q    <= done_d;
      match_q   <= match_d;
      gcall_q   <= gcall_d;
      rw_q      <= rw_d;
      idx_q     <= idx_d;
    end
  end

  assign done_o      = done_q;
  assign match_o     = match_q;
  assign match_idx_o = idx_q;
  assign gcall_o     = gcall_q;
  assign rw_o        = rw_q;

  assert_disable_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!done_o && !match_o && !gcall_o && !rw_o));

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && start_i && !free_data_i) |=> (!done_o && !match_o && !gcall_o));

  assert_match_has_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o);

  assert_done_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(byte_valid_i) || $past(start_i && free_data_i)));

  assert_gcall_slot0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_o |-> (match_o && match_idx_o == '0 && !rw_o));

  assert_grant_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~req) == '0));

  assert_free_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && start_i && free_data_i) |=> (done_o && match_o && !gcall_o));

  assert_hold_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enable_i && !start_i) |=>
      (done_o && $stable(match_o) && $stable(match_idx_o) && $stable(gcall_o) && $stable(rw_o)));
endmodule

// File: tb/i2c_addr_matcher_tb.sv
module i2c_addr_matcher_tb_top;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, start = 1'b0, bvalid = 1'b0, free_d = 1'b0, ten = 1'b0;
  logic [7:0] bdata = '0;
  logic [NS*10-1:0] slots = '0;
  logic done, match, gcall, rw;
  logic [1:0] idx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_matcher #(.NUM_SLOTS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .start_i(start),
    .byte_valid_i(bvalid), .byte_i(bdata), .free_data_i(free_d), .ten_bit_i(ten),
    .slot_addr_i(slots), .done_o(done), .match_o(match), .match_idx_o(idx),
    .gcall_o(gcall), .rw_o(rw)
  );

  // {done, match, idx[1:0], gcall, rw}
  function automatic logic [5:0] outs();
    return {done, match, idx, gcall, rw};
  endfunction

  function automatic logic [5:0] model(input logic [NS*10-1:0] s, input logic tb,
                                       input logic [7:0] b1, input logic [7:0] b2);
    logic [5:0] r;
    r = {1'b1, 1'b0, 2'd0, 1'b0, b1[0]};
    if (b1 == 8'h00) return 6'b11_00_10;
    if (!tb) begin
      for (int i = NS - 1; i >= 0; i--)
        if (s[i*10+3 +: 7] == b1[7:1]) r = {1'b1, 1'b1, 2'(i), 1'b0, b1[0]};
    end else if (b1[7:3] == 5'b11110) begin
      for (int i = NS - 1; i >= 0; i--)
        if (s[i*10+8 +: 2] == b1[2:1] && s[i*10 +: 8] == b2)
          r = {1'b1, 1'b1, 2'(i), 1'b0, b1[0]};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b (done,match,idx,gcall,rw)", tag, got, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bdata = b; bvalid = 1'b1; @(negedge clk); bvalid = 1'b0;
  endtask

  function automatic logic [9:0] a7(input logic [6:0] a, input logic [2:0] junk);
    return {a, junk};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    slots = {a7(7'h7F, 3'd5), a7(7'h3A, 3'd2), a7(7'h15, 3'd7)};
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 6'b0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), 6'b0);
    send_byte(8'h2A);
    check("R1 byte before START ignored", outs(), 6'b0);

    // R3 R4 R6 R9: 7-bit sweep over three slot sets
    for (int set = 0; set < 3; set++) begin
      case (set)
        0: slots = {a7(7'h7F, 3'd5), a7(7'h3A, 3'd2), a7(7'h15, 3'd7)};
        1: slots = {a7(7'h22, 3'd1), a7(7'h22, 3'd6), a7(7'h50, 3'd3)};
        default: slots = {a7(7'h11, 3'd4), a7(7'h00, 3'd0), a7(7'h11, 3'd3)};
      endcase
      for (int b = 0; b < 256; b++) begin
        pulse_start();
        check("R2 cleared after START", outs(), 6'b0);
        send_byte(8'(b));
        check("R3/R4/R6/R9 7-bit decision", outs(), model(slots, 1'b0, 8'(b), 8'h00));
      end
    end

    // R5 R6: 10-bit sweep, slot2 duplicates slot0
    ten = 1'b1;
    slots = {10'h2A5, 10'h1A5, 10'h2A5};
    for (int hi = 0; hi < 4; hi++) begin
      for (int d = 0; d < 2; d++) begin
        for (int lo = 0; lo < 256; lo++) begin
          logic [7:0] b1;
          b1 = {5'b11110, 2'(hi), 1'(d)};
          pulse_start();
          send_byte(b1);
          check("R5 no decision after prefix byte", {done, match}, 6'b0);
          send_byte(8'(lo));
          check("R5/R6 10-bit decision", outs(), model(slots, 1'b1, b1, 8'(lo)));
        end
      end
    end
    // R4 R9: 10-bit first bytes without prefix
    for (int b = 0; b < 256; b++) begin
      if (b[7:3] != 5'b11110) begin
        pulse_start();
        send_byte(8'(b));
        check("R4/R9 10-bit non-prefix first byte", outs(), model(slots, 1'b1, 8'(b), 8'h00));
      end
    end

    // R8: later bytes ignored after decision
    ten = 1'b0;
    slots = {a7(7'h7F, 3'd0), a7(7'h3A, 3'd0), a7(7'h15, 3'd0)};
    pulse_start();
    send_byte({7'h3A, 1'b1});
    held = outs();
    check("R3 directed match slot1 read", held, 6'b11_01_01);
    send_byte({7'h15, 1'b0});
    check("R8 second byte ignored", outs(), held);
    send_byte(8'h00);
    check("R8 zero byte ignored", outs(), held);

    // R2: START and strobe in the same cycle
    start = 1'b1; bdata = {7'h15, 1'b0}; bvalid = 1'b1;
    @(negedge clk);
    start = 1'b0; bvalid = 1'b0;
    check("R2 coincident START clears", outs(), 6'b0);
    @(negedge clk);
    check("R2 coincident byte discarded", outs(), 6'b0);
    send_byte({7'h15, 1'b0});
    check("R2 match after coincident START", outs(), 6'b11_00_00);

    // R1: disable
    enable = 1'b0;
    @(negedge clk);
    check("R1 disable clears", outs(), 6'b0);
    pulse_start();
    send_byte({7'h15, 1'b0});
    check("R1 START while disabled ignored", outs(), 6'b0);
    enable = 1'b1;
    @(negedge clk);
    send_byte({7'h15, 1'b0});
    check("R1 no START after enable", outs(), 6'b0);

    // R7: free data
    free_d = 1'b1;
    pulse_start();
    check("R7 free data accept", outs(), 6'b11_00_00);
    send_byte(8'h00);
    check("R7 byte ignored in free data", outs(), 6'b11_00_00);
    send_byte({7'h7F, 1'b1});
    check("R7 address byte ignored", outs(), 6'b11_00_00);
    free_d = 1'b0;
    pulse_start();
    check("R2 START leaves free data", outs(), 6'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule